// File: doc/BRIEF.md
# Data-Memory Front End with Display and Switch Port

This block is the data-side memory of a small pipelined processor. The pipeline presents one word access per cycle: an address, write data and a write enable. It receives one registered read word. Address bit 31 picks the target. With the bit clear, the access goes to an internal word RAM. With the bit set, it goes to a small peripheral.

The peripheral has two 32-bit display registers, which software writes and reads back. It also has a read-only view of an external switch bus. The switch bus is asynchronous, so it passes through a two-flop synchronizer before it can reach the read word. An external output bus shows one display register at all times, and a select pin chooses which one, combinationally.

The read word feeds the processor's write-back mux directly. Every result is therefore due exactly one rising edge after its address is presented. An access to an IO address that maps to nothing leaves the read word at its previous value, whichever target produced that value.

Top module: `dmem_front`

## Requirements
- R1: With address bit 31 clear, a RAM word written at an address is returned on `rd_data` one rising edge after a later read of that address.
- R2: A write with address bit 31 set never alters any RAM word, even when its low address bits match a stored word.
- R3: A write at 0xFFFFFFF0 loads display register 0 and a write at 0xFFFFFFF4 loads display register 1; reading those addresses returns the stored values.
- R4: A write to any other address with bit 31 set, 0xFFFFFFF8 included, changes neither display register. This is visible on readback and on `disp_out`.
- R5: `disp_out` equals display register 1 while `disp_sel` is 1 and display register 0 while it is 0, in the same cycle and with no clock edge.
- R6: When a display register is written and read in the same cycle, `rd_data` returns the value it held before that edge.
- R7: A read of 0xFFFFFFF8 returns `sw_in` as it was two rising edges before the capturing edge, through a two-flop synchronizer, on all 32 bits.
- R8: A read of an IO address other than 0xFFFFFFF0, 0xFFFFFFF4 or 0xFFFFFFF8 leaves `rd_data` unchanged, including when the previous value came from the RAM.
- R9: A synchronous active-high `rst` clears both display registers, the synchronizer and `rd_data` to zero at the next rising edge. RAM contents are not cleared.
- R10: A RAM write and read of the same word in one cycle returns the old word, and the new word is returned from the next read.
- R11: The RAM is indexed by address bits [RAM_AW+1:2], so addresses that differ by 4*2^RAM_AW select the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | input | 32 | Byte address of the access; bit 31 selects the peripheral |
| mem_wdata | input | 32 | Write data |
| mem_we | input | 1 | Write enable for the addressed target |
| rd_data | output | 32 | Registered read word, due one edge after the address |
| sw_in | input | 32 | Asynchronous switch bus |
| disp_sel | input | 1 | Chooses which display register drives `disp_out` |
| disp_out | output | 32 | Combinational display output |

## Verification
Every read result on `rd_data` is due one rising edge after its access is driven. The bench drives each access at a falling edge and queues the value it expects for that access. It then compares the queue head with `rd_data` 1 ns after the next rising edge, so one item stands for exactly one edge. Switch-bus reads are expected two edges behind the bus: the reference model shifts its own two-stage copy of `sw_in` once per driven cycle. `disp_out` has no latency, so it is compared 1 ns after the falling edge at which `disp_sel` and the access change. It is compared against display register contents as they stood after the previous rising edge.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam logic [31:0] DISP0_ADDR = 32'hFFFF_FFF0;
  localparam logic [31:0] DISP1_ADDR = 32'hFFFF_FFF4;
  localparam logic [31:0] SWIN_ADDR  = 32'hFFFF_FFF8;

  typedef enum logic [1:0] {
    IOSEL_DISP0 = 2'd0,
    IOSEL_DISP1 = 2'd1,
    IOSEL_SWIN  = 2'd2,
    IOSEL_NONE  = 2'd3
  } io_target_e;

  function automatic io_target_e io_decode(input logic [31:0] a);
    io_target_e t;
    case (a)
      DISP0_ADDR: t = IOSEL_DISP0;
      DISP1_ADDR: t = IOSEL_DISP1;
      SWIN_ADDR:  t = IOSEL_SWIN;
      default:    t = IOSEL_NONE;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/dmem_sync2.sv
module dmem_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] safe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= d;
      safe_q <= meta_q;
    end
  end

  assign q = safe_q;

endmodule

// File: rtl/dmem_word_ram.sv
module dmem_word_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  // Write port: plain array write, inferable as block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  // Read port: output register with enable and synchronous reset.
  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (re) rd_q <= mem[idx];
  end

  assign rdata = rd_q;

  // R9
  ram_rst_chk: assert property (@(posedge clk) rst |=> (rdata == '0));

  // R8
  ram_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));

endmodule

// File: rtl/dmem_io_port.sv
module dmem_io_port
  import dmem_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          we,
  input  logic [31:0]   addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] sw_sync,
  input  logic          disp_sel,
  output logic [DW-1:0] disp_out,
  output logic [DW-1:0] rdata,
  output logic          rd_hit
);

  io_target_e    tgt;
  logic [DW-1:0] disp0_q;
  logic [DW-1:0] disp1_q;
  logic [DW-1:0] rd_q;

  assign tgt    = io_decode(addr);
  assign rd_hit = acc && (tgt != IOSEL_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      disp0_q <= '0;
      disp1_q <= '0;
    end else if (we) begin
      if (tgt == IOSEL_DISP0) disp0_q <= wdata;
      if (tgt == IOSEL_DISP1) disp1_q <= wdata;
    end
  end

  // Read register: nonblocking capture returns pre-write contents.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (acc) begin
      case (tgt)
        IOSEL_DISP0: rd_q <= disp0_q;
        IOSEL_DISP1: rd_q <= disp1_q;
        IOSEL_SWIN:  rd_q <= sw_sync;
        default:     rd_q <= rd_q;
      endcase
    end
  end

  assign disp_out = disp_sel ? disp1_q : disp0_q;
  assign rdata    = rd_q;

  // R3
  disp0_load_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == DISP0_ADDR) |=> (disp0_q == $past(wdata)));

  // R3
  disp1_load_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == DISP1_ADDR) |=> (disp1_q == $past(wdata)));

  // R4
  io_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr != DISP0_ADDR && addr != DISP1_ADDR)
      |=> ($stable(disp0_q) && $stable(disp1_q)));

  // R6
  io_rdfirst_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && addr == DISP0_ADDR) |=> (rdata == $past(disp0_q)));

endmodule

// File: rtl/dmem_front.sv
module dmem_front
  import dmem_pkg::*;
#(
  parameter int RAM_AW = 8,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [31:0]   mem_addr,
  input  logic [DW-1:0] mem_wdata,
  input  logic          mem_we,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] sw_in,
  input  logic          disp_sel,
  output logic [DW-1:0] disp_out
);

  localparam int IDX_LO = 2;
  localparam int IDX_HI = RAM_AW + IDX_LO - 1;

  logic          io_acc;
  logic          ram_we;
  logic          io_we;
  logic          io_hit;
  logic          src_io_q;
  logic [DW-1:0] ram_rd;
  logic [DW-1:0] io_rd;
  logic [DW-1:0] sw_sync;

  assign io_acc = mem_addr[31];
  assign ram_we = mem_we & ~io_acc;
  assign io_we  = mem_we &  io_acc;

  dmem_sync2 #(.W(DW)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sw_in),
    .q   (sw_sync)
  );

  dmem_word_ram #(.AW(RAM_AW), .DW(DW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (ram_we),
    .re    (~io_acc),
    .idx   (mem_addr[IDX_HI:IDX_LO]),
    .wdata (mem_wdata),
    .rdata (ram_rd)
  );

  dmem_io_port #(.DW(DW)) u_io (
    .clk      (clk),
    .rst      (rst),
    .acc      (io_acc),
    .we       (io_we),
    .addr     (mem_addr),
    .wdata    (mem_wdata),
    .sw_sync  (sw_sync),
    .disp_sel (disp_sel),
    .disp_out (disp_out),
    .rdata    (io_rd),
    .rd_hit   (io_hit)
  );

  // Remembers which target produced the last valid read word.
  always_ff @(posedge clk) begin
    if (rst)          src_io_q <= 1'b0;
    else if (!io_acc) src_io_q <= 1'b0;
    else if (io_hit)  src_io_q <= 1'b1;
  end

  assign rd_data = src_io_q ? io_rd : ram_rd;

  // R2
  wr_steer_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, io_we}));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (io_acc && !io_hit) |=> $stable(rd_data));

  // R9
  rst_clear_chk: assert property (@(posedge clk) rst |=> (rd_data == '0));

endmodule

// File: tb/dmem_front_test.sv
`timescale 1ns/1ps
module dmem_front_test;

  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [31:0] A_D0 = 32'hFFFF_FFF0;
  localparam logic [31:0] A_D1 = 32'hFFFF_FFF4;
  localparam logic [31:0] A_SW = 32'hFFFF_FFF8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic        disp_sel = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] sw_in = '0;
  logic [31:0] rd_data;
  logic [31:0] disp_out;

  always #2.5 clk = ~clk;

  dmem_front #(.RAM_AW(AW), .DW(32)) uut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (addr),
    .mem_wdata (wdata),
    .mem_we    (we),
    .rd_data   (rd_data),
    .sw_in     (sw_in),
    .disp_sel  (disp_sel),
    .disp_out  (disp_out)
  );

  typedef struct {
    bit          chk;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   tests = 0;
  int   fails = 0;

  // Reference model state
  logic [31:0] m_ram [int];
  logic [31:0] m_d0 = '0, m_d1 = '0, m_rd = '0, m_s1 = '0, m_s2 = '0;
  logic [31:0] sw_next = '0;

  // Driver: one access per cycle, expectation queued for the next edge.
  task automatic step(input logic r, input logic [31:0] a, input logic w,
                      input logic [31:0] d, input bit chk, input bit oc,
                      input string tag);
    exp_t        it;
    logic [31:0] e;
    int          idx;
    @(negedge clk);
    rst = r; addr = a; we = w; wdata = d; sw_in = sw_next;
    #1;
    if (oc) begin
      tests++;
      if (disp_out !== (disp_sel ? m_d1 : m_d0)) begin
        fails++;
        $display("FAIL %s disp_out actual %h expected %h", tag, disp_out,
                 disp_sel ? m_d1 : m_d0);
      end
    end
    idx = int'(a[AW+1:2]);
    if (r) begin
      e = '0; m_d0 = '0; m_d1 = '0; m_s1 = '0; m_s2 = '0;
    end else if (!a[31]) begin
      e = m_ram.exists(idx) ? m_ram[idx] : 'x;
      if (w) m_ram[idx] = d;
    end else begin
      case (a)
        A_D0:    e = m_d0;
        A_D1:    e = m_d1;
        A_SW:    e = m_s2;
        default: e = m_rd;
      endcase
      if (w && a == A_D0) m_d0 = d;
      if (w && a == A_D1) m_d1 = d;
    end
    if (!r) begin
      m_s2 = m_s1;
      m_s1 = sw_in;
    end
    m_rd = e;
    it.chk = chk; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: pops one item per rising edge, samples 1 ns after it.
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        if (it.chk) begin
          tests++;
          if (rd_data !== it.exp) begin
            fails++;
            $display("FAIL %s rd_data actual %h expected %h", it.tag, rd_data, it.exp);
          end
        end
      end
    end
  end

  initial begin
    #(50000 * 5);
    fails++;
    $display("FAIL watchdog expired, all requirements unfinished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R9: reset state
    step(1, 32'h0, 0, 0, 1, 0, "R9");
    step(1, 32'h0, 0, 0, 1, 0, "R9");
    step(0, 32'hFFFF_FF00, 0, 0, 1, 1, "R9");
    // R1, R10: RAM path
    step(0, 32'h10, 1, 32'h1111_0001, 0, 0, "R1");
    step(0, 32'h10, 0, 0, 1, 0, "R1");
    step(0, 32'h10, 1, 32'h2222_0002, 1, 0, "R10");
    step(0, 32'h10, 0, 0, 1, 0, "R10");
    // R3, R5, R6: display registers
    step(0, A_D0, 1, 32'hC0DE_0001, 0, 0, "R3");
    step(0, A_D1, 1, 32'hC0DE_0002, 0, 0, "R3");
    step(0, A_D0, 0, 0, 1, 1, "R3 R5");
    step(0, A_D1, 0, 0, 1, 0, "R3");
    step(0, A_D0, 1, 32'hC0DE_0003, 1, 0, "R6");
    step(0, A_D0, 0, 0, 1, 1, "R6 R5");
    disp_sel = 1'b1;
    step(0, A_D1, 0, 0, 1, 1, "R5");
    disp_sel = 1'b0;
    step(0, A_D1, 0, 0, 1, 1, "R5");
    // R4, R2: ignored IO writes
    step(0, 32'hFFFF_FFFC, 1, 32'hDEAD_0000, 0, 0, "R4");
    step(0, 32'h8000_0010, 1, 32'hBEEF_0000, 0, 0, "R4");
    step(0, A_SW, 1, 32'hBAD0_0000, 0, 0, "R4");
    step(0, A_D0, 0, 0, 1, 1, "R4");
    disp_sel = 1'b1;
    step(0, A_D1, 0, 0, 1, 1, "R4");
    disp_sel = 1'b0;
    step(0, 32'h10, 0, 0, 1, 0, "R2");
    step(0, 32'h14, 1, 32'h3333_0003, 0, 0, "R2");
    step(0, 32'h8000_0014, 1, 32'h4444_0004, 0, 0, "R2");
    step(0, 32'h14, 0, 0, 1, 0, "R2");
    // R11: index aliasing
    step(0, 32'h10 + 4 * DEPTH, 0, 0, 1, 0, "R11");
    step(0, 32'h18 + 4 * DEPTH, 1, 32'h5555_0005, 0, 0, "R11");
    step(0, 32'h18, 0, 0, 1, 0, "R11");
    // R7: synchronized switch bus
    sw_next = 32'h0000_00A5;
    step(0, 32'hFFFF_FF00, 0, 0, 0, 0, "R7");
    step(0, 32'hFFFF_FF00, 0, 0, 0, 0, "R7");
    step(0, A_SW, 0, 0, 1, 0, "R7");
    sw_next = 32'hFFFF_FF3C;
    step(0, A_SW, 0, 0, 1, 0, "R7");
    step(0, A_SW, 0, 0, 1, 0, "R7");
    step(0, A_SW, 0, 0, 1, 0, "R7");
    // R8: hold on unmapped IO reads
    step(0, 32'hFFFF_FF00, 0, 0, 1, 0, "R8");
    step(0, 32'h14, 0, 0, 1, 0, "R8");
    step(0, 32'hFFFF_FF04, 0, 0, 1, 0, "R8");
    step(0, 32'h8000_0000, 0, 0, 1, 0, "R8");
    // R9: mid-run reset
    step(1, A_D0, 0, 0, 1, 0, "R9");
    step(0, A_D0, 0, 0, 1, 1, "R9");
    step(0, A_D1, 0, 0, 1, 0, "R9");
    step(0, 32'hFFFF_FF00, 0, 0, 0, 0, "idle");
    @(negedge clk);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule